// File: doc/BRIEF.md
# Variable Phase Shift Step Controller

This block is the digital control section of a fine phase-shift unit inside a clock manager. It keeps one signed count of delay steps, and that count applies to every output of the clock manager at once. On each phase-shift-clock cycle with the enable input active, the block accepts an adjustment request. The direction input decides whether the request adds one step or removes one step.

The change does not take effect at once. The request crosses into the input-clock domain, where a counter models the settling time of the delay line. A completion event then comes back to the phase-shift-clock domain. At that point the step count is updated and a one-cycle done pulse tells the user that the next request may be issued.

The count is limited in both directions to a magnitude derived from the input clock period. The multiplier is 10 for a slow input clock and 15 for a fast one, applied to the period minus 3 ns. The period, the range select, the settling length and the polarity of the enable and direction inputs are all parameters.

Top module: `phase_step_ctrl`

## Requirements
- R1: While `rst_n` is low, `step_value` is 0 and `ps_done` is 0. Asserting reset at any time returns the count to 0.
- R2: An accepted request with the effective direction High (1 = increment) raises `step_value` by exactly 1.
- R3: An accepted request with the effective direction Low (0 = decrement) lowers `step_value` by exactly 1.
- R4: Each accepted request produces exactly one `ps_done` pulse, one `ps_clk` cycle wide. `step_value` changes only on the edge that raises `ps_done`.
- R5: The done pulse comes no earlier than `SETTLE_CYC` input-clock cycles after the request, plus the synchronizer stages in both domains.
- R6: An enable that arrives while a request is still in progress is ignored. It produces no extra done pulse and no extra change of the count.
- R7: The limit is LIMIT = K × (`TIN_NS` − 3), with K = 15 when `FAST_RANGE` = 1 and K = 10 otherwise. An increment at +LIMIT leaves the count unchanged but still produces a done pulse.
- R8: A decrement at −LIMIT leaves the count unchanged but still produces a done pulse.
- R9: Cycles in which the effective enable is Low cause no done pulse and no change of the count, whatever the direction input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ps_clk | input | 1 | Phase-shift clock; times every request and the done pulse |
| in_clk | input | 1 | Input clock; times the settling counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ps_en | input | 1 | Request enable; polarity set by `EN_INV` |
| ps_dir | input | 1 | Direction, 1 = increment, 0 = decrement; polarity set by `DIR_INV` |
| ps_done | output | 1 | One-cycle pulse when an adjustment has completed |
| step_value | output | STEP_W | Current signed step count |

## Verification
The bench builds the block with `TIN_NS` = 4 and `FAST_RANGE` = 1, which gives a limit of 15. Both clamps can then be reached within sixteen requests, and the bench steps the count past each limit. `SETTLE_CYC` = 6 makes each request round trip short enough to run dozens of them. The bench also measures every done latency against a lower and an upper time window, so a missing or bypassed settling counter shows up in the measurements. Both polarity settings stay at their defaults, so the bench drives the enable and direction inputs at their natural levels.

// File: rtl/phs_pkg.sv
package phs_pkg;
  // Step magnitude limit: K * (period_ns - 3), K = 15 fast, 10 slow.
  function automatic int step_limit(input int tin_ns, input bit fast);
    int k;
    k = fast ? 15 : 10;
    if (tin_ns <= 3) return 0;
    return k * (tin_ns - 3);
  endfunction
endpackage

// File: rtl/phs_rst_sync.sv
module phs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/phs_tgl_sync.sv
module phs_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  localparam int W = STAGES + 1;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[W-2:0], tgl_in};
  end

  assign pulse = sh_q[W-1] ^ sh_q[W-2];
endmodule

// File: rtl/phs_settle.sv
module phs_settle #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic ack_tgl
);
  localparam int CW = $clog2(SETTLE_CYC) + 1;
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

  logic          start;
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;

  phs_tgl_sync #(.STAGES(2)) u_req_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl_in (req_tgl),
    .pulse  (start)
  );

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    ack_d = ack_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = LOAD;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d = 1'b0;
        ack_d = ~ack_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      ack_q <= ack_d;
    end
  end

  assign ack_tgl = ack_q;
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int TIN_NS     = 20,
  parameter bit FAST_RANGE = 1'b0,
  parameter int SETTLE_CYC = 100,
  parameter bit EN_INV     = 1'b0,
  parameter bit DIR_INV    = 1'b0,
  parameter int STEP_W     = 10
) (
  input  logic                     ps_clk,
  input  logic                     in_clk,
  input  logic                     rst_n,
  input  logic                     ps_en,
  input  logic                     ps_dir,
  output logic                     ps_done,
  output logic signed [STEP_W-1:0] step_value
);
  localparam int LIMIT = phs_pkg::step_limit(TIN_NS, FAST_RANGE);
  localparam logic signed [STEP_W-1:0] POS_LIM = STEP_W'(LIMIT);
  localparam logic signed [STEP_W-1:0] NEG_LIM = -POS_LIM;

  logic ps_rst_n, in_rst_n;
  logic ack_tgl, ack_pulse;
  logic en_eff, dir_eff, accept;

  logic                     busy_q, busy_d;
  logic                     dir_q, dir_d;
  logic                     req_q, req_d;
  logic                     done_q;
  logic signed [STEP_W-1:0] step_q, step_d;

  phs_rst_sync u_ps_rst (.clk(ps_clk), .rst_n(rst_n), .rst_sync_n(ps_rst_n));
  phs_rst_sync u_in_rst (.clk(in_clk), .rst_n(rst_n), .rst_sync_n(in_rst_n));

  phs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (in_clk),
    .rst_n   (in_rst_n),
    .req_tgl (req_q),
    .ack_tgl (ack_tgl)
  );

  phs_tgl_sync #(.STAGES(2)) u_ack_sync (
    .clk    (ps_clk),
    .rst_n  (ps_rst_n),
    .tgl_in (ack_tgl),
    .pulse  (ack_pulse)
  );

  assign en_eff  = ps_en ^ EN_INV;
  assign dir_eff = ps_dir ^ DIR_INV;
  assign accept  = en_eff & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    req_d  = req_q;
    step_d = step_q;
    if (ack_pulse) begin
      busy_d = 1'b0;
      if (dir_q && (step_q < POS_LIM))      step_d = step_q + 1'b1;
      else if (!dir_q && (step_q > NEG_LIM)) step_d = step_q - 1'b1;
    end
    if (accept) begin
      busy_d = 1'b1;
      dir_d  = dir_eff;
      req_d  = ~req_q;
    end
  end

  always_ff @(posedge ps_clk or negedge ps_rst_n) begin
    if (!ps_rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      req_q  <= req_d;
      done_q <= ack_pulse;
      step_q <= step_d;
    end
  end

  assign ps_done    = done_q;
  assign step_value = step_q;
endmodule

// File: rtl/phs_checker.sv
module phs_checker #(
  parameter int STEP_W = 10,
  parameter int LIMIT  = 0
) (
  input logic                     ps_clk,
  input logic                     rst_n,
  input logic                     ps_done,
  input logic signed [STEP_W-1:0] step_value
);
  localparam logic signed [STEP_W-1:0] LIM = STEP_W'(LIMIT);

  assert_done_single_R4: assert property (@(posedge ps_clk) disable iff (!rst_n)
    ps_done |=> !ps_done);

  assert_step_on_done_R4: assert property (@(posedge ps_clk) disable iff (!rst_n)
    (step_value != $past(step_value)) |-> ps_done);

  assert_step_unit_R2: assert property (@(posedge ps_clk) disable iff (!rst_n)
    ps_done |-> ((step_value == $past(step_value)) ||
                 (step_value == $past(step_value) + 1'b1) ||
                 (step_value == $past(step_value) - 1'b1)));

  assert_step_range_R7: assert property (@(posedge ps_clk) disable iff (!rst_n)
    (step_value <= LIM) && (step_value >= -LIM));
endmodule

bind phase_step_ctrl phs_checker #(.STEP_W(STEP_W), .LIMIT(LIMIT)) u_chk (
  .ps_clk     (ps_clk),
  .rst_n      (rst_n),
  .ps_done    (ps_done),
  .step_value (step_value)
);

// File: tb/sim_phase_step_ctrl.sv
`timescale 1ns/100ps
module sim_phase_step_ctrl;
  localparam int TIN   = 4;
  localparam int SETL  = 6;
  localparam int LIMIT = 15;
  localparam int NV    = 10;
  // [8] = direction, [7:0] = expected signed count after the request
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'sd1}, {1'b1, 8'sd2}, {1'b1, 8'sd3}, {1'b0, 8'sd2}, {1'b0, 8'sd1},
    {1'b0, 8'sd0}, {1'b0, -8'sd1}, {1'b0, -8'sd2}, {1'b1, -8'sd1}, {1'b0, -8'sd2}};

  logic ps_clk = 1'b0, in_clk = 1'b0, rst_n = 1'b0, ps_en = 1'b0, ps_dir = 1'b0;
  logic ps_done;
  logic signed [9:0] step_value;
  int total = 0, bad = 0;

  always #5   ps_clk = ~ps_clk;
  always #3.5 in_clk = ~in_clk;

  phase_step_ctrl #(.TIN_NS(TIN), .FAST_RANGE(1'b1), .SETTLE_CYC(SETL),
                    .EN_INV(1'b0), .DIR_INV(1'b0), .STEP_W(10)) u0 (
    .ps_clk(ps_clk), .in_clk(in_clk), .rst_n(rst_n), .ps_en(ps_en),
    .ps_dir(ps_dir), .ps_done(ps_done), .step_value(step_value));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one request, wait for done, check latency window and pulse width.
  task automatic issue(input bit dir, input string req);
    realtime t0, lat;
    bit got;
    @(negedge ps_clk); ps_en = 1'b1; ps_dir = dir; t0 = $realtime + 5.0;
    @(negedge ps_clk); ps_en = 1'b0;
    got = 1'b0; lat = 0.0;
    for (int i = 0; i < 100 && !got; i++) begin
      if (ps_done) begin got = 1'b1; lat = $realtime - 5.0 - t0; end
      else @(negedge ps_clk);
    end
    check(got, {req, " done seen"}, int'(got), 1);
    check(lat >= 70.0 && lat <= 250.0, "R5 latency window", int'(lat), 70);
    @(negedge ps_clk);
    check(!ps_done, "R4 done one cycle", int'(ps_done), 0);
  endtask

  task automatic do_reset();
    @(negedge ps_clk); rst_n = 1'b0;
    @(negedge ps_clk);
    check(step_value == 0 && !ps_done, "R1 reset state", int'(step_value), 0);
    repeat (2) @(negedge ps_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge ps_clk);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge ps_clk);
    check(step_value == 0 && !ps_done, "R1 in reset", int'(step_value), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge ps_clk);

    // R2/R3 table walk
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][8], VEC[v][8] ? "R2" : "R3");
      check(step_value == 10'(signed'(VEC[v][7:0])), VEC[v][8] ? "R2 inc" : "R3 dec",
            int'(step_value), int'(signed'(VEC[v][7:0])));
    end

    // R9: enable low, direction toggling
    for (int i = 0; i < 40; i++) begin
      @(negedge ps_clk); ps_dir = ~ps_dir;
      check(!ps_done, "R9 no done while idle", int'(ps_done), 0);
    end
    check(step_value == -2, "R9 count unchanged", int'(step_value), -2);

    // R6: second enable while busy is ignored
    @(negedge ps_clk); ps_en = 1'b1; ps_dir = 1'b1;
    @(negedge ps_clk); ps_en = 1'b0;
    repeat (2) @(negedge ps_clk);
    ps_en = 1'b1;
    @(negedge ps_clk); ps_en = 1'b0;
    begin
      int pulses = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge ps_clk);
        if (ps_done) pulses++;
      end
      check(pulses == 1, "R6 single done", pulses, 1);
    end
    check(step_value == -1, "R6 single step", int'(step_value), -1);

    // R1: reset mid-run returns to zero
    do_reset();

    // R7: upper clamp
    for (int i = 0; i < LIMIT; i++) issue(1'b1, "R7");
    check(step_value == LIMIT, "R7 reach limit", int'(step_value), LIMIT);
    issue(1'b1, "R7 clamp");
    check(step_value == LIMIT, "R7 held at limit", int'(step_value), LIMIT);
    issue(1'b0, "R3");
    check(step_value == LIMIT - 1, "R3 dec from limit", int'(step_value), LIMIT - 1);

    do_reset();

    // R8: lower clamp
    for (int i = 0; i < LIMIT; i++) issue(1'b0, "R8");
    check(step_value == -LIMIT, "R8 reach limit", int'(step_value), -LIMIT);
    issue(1'b0, "R8 clamp");
    check(step_value == -LIMIT, "R8 held at limit", int'(step_value), -LIMIT);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule